// File: doc/BRIEF.md
# Serial ADC Command Byte Front End

This block is the digital half of a small multichannel serial converter, seen from a byte-wide serial bus. Each bus transfer delivers one byte to the block and takes one byte back. A byte whose top bit is set is a command. It selects an input channel, single-ended or differential measurement, unipolar or bipolar coding, and whether the converter stays powered. A byte with the top bit clear is only a filler that clocks the reply out.

When a powered command arrives, the block takes two stored 8-bit samples and subtracts them. The second operand is either the common reference or the partner channel. It then codes the 8-bit difference and keeps it for the two replies that follow. The sample registers and the common reference are loaded through a separate write port. A parameter picks a 4-input or an 8-input build. An interrupt line rises on every powered command and falls on the next filler byte.

The sequencer has four states:
- `SQ_IDLE`: no valid command is held.
- `SQ_HIGH`: the upper reply is due next.
- `SQ_LOW`: the lower reply is due next.
- `SQ_DONE`: the reply is used up.

It has four transitions:
- ARM: a powered command, from any state, goes to `SQ_HIGH`.
- SLEEP: a command with the power bit clear, from any state, goes to `SQ_IDLE`.
- ADVANCE: a filler byte moves `SQ_HIGH` to `SQ_LOW`, and `SQ_LOW` to `SQ_DONE`.
- HOLD: a filler byte leaves `SQ_IDLE` or `SQ_DONE` unchanged.

Top module: `adc_spi_frontend`

## Requirements
- R1: A received byte with bit 7 clear is not a command. It leaves the stored result unchanged and only moves the reply sequence along (R9).
- R2: A command byte (bit 7 set) with bit 1 (power) clear discards the held command. The reply for it, and for every later filler byte, is 0x00 until a powered command arrives.
- R3: In the 8-input build, the channel index is {bit5, bit4, bit6} of the command, most significant first.
- R4: In the 4-input build, bit 4 is ignored and the channel index is {bit5, bit6}.
- R5: With bit 2 set (single-ended), the measurement is the selected sample minus the common reference, modulo 256. The reference is 0x00 after reset and is loaded through com_wr_en.
- R6: With bit 2 clear (differential), the measurement is the selected sample minus the sample at index XOR 1, modulo 256.
- R7: With bit 3 clear (bipolar), bit 7 of the measurement is inverted. With bit 3 set, the measurement is passed unchanged.
- R8: The first reply after a command is {2'b00, m[7:2]}. The second is {m[1:0], 6'b000000}.
- R9: The reply to a command byte is 0x00. Every reply after the second result byte is 0x00. A new command always restarts the sequence.
- R10: Reset clears the result, the sequence and the interrupt. It loads sample i with 0xF0 minus 0x10 times i.
- R11: irq is 1 after every powered command. It is 0 after any byte with bit 7 clear. Otherwise it keeps its value.
- R12: tx_valid pulses for one cycle, on the clock after each rx_valid cycle, and carries that transfer's reply. tx_byte is 0x00 when tx_valid is low.
- R13: A sample write changes the stored value of that channel, and later commands use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | One byte transfer this cycle |
| rx_byte | input | 8 | Byte received from the bus master |
| tx_valid | output | 1 | Reply for the previous transfer is present |
| tx_byte | output | 8 | Reply byte |
| irq | output | 1 | Conversion-ready interrupt |
| smp_wr_en | input | 1 | Sample register write strobe |
| smp_wr_idx | input | IDX_W | Sample register index |
| smp_wr_data | input | DW | Sample value |
| com_wr_en | input | 1 | Common reference write strobe |
| com_wr_data | input | DW | Common reference value |

## Verification
The bench drives every channel and mode combination through both builds. It uses custom sample values with nonzero low bits, so the two lowest measurement bits are exercised. A wrong select-bit permutation would read a neighbouring channel, and a dropped XOR on the pair would subtract a channel from itself. Other corner cases are:
- a reference larger than the sample, which catches a subtraction that saturates instead of wrapping;
- a command in the middle of a reply, which must restart the sequence;
- an unpowered command, which must silence all later replies;
- a filler byte carrying random low bits, which must neither re-arm nor alter the result;
- a reset in the middle of a sequence, which must restore the default samples.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HIGH = 2'd1,
        SQ_LOW  = 2'd2,
        SQ_DONE = 2'd3
    } seq_state_t;

    // Packed so that a received byte casts directly onto it
    typedef struct packed {
        logic       start;
        logic [2:0] sel;
        logic       uni;
        logic       sgl;
        logic       pwr;
        logic       pd0;
    } ctrl_t;

    function automatic logic [7:0] sample_default(input int idx);
        return 8'(240 - 16 * idx);
    endfunction

endpackage

// File: rtl/adc_fe_chan_map.sv
module adc_fe_chan_map
    import adc_fe_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  ctrl_t              ctrl,
    output logic [IDX_W-1:0]   sel_idx,
    output logic [IDX_W-1:0]   pair_idx
);

    generate
        if (NUM_CH == 8) begin : g_eight
            always_comb begin
                sel_idx = {ctrl.sel[1], ctrl.sel[0], ctrl.sel[2]};
            end
        end else begin : g_four
            always_comb begin
                sel_idx = {ctrl.sel[1], ctrl.sel[2]};
            end
        end
    endgenerate

    always_comb begin
        pair_idx = sel_idx ^ IDX_W'(1);
    end

endmodule

// File: rtl/adc_fe_sample_bank.sv
module adc_fe_sample_bank
    import adc_fe_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 8,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              com_wr_en,
    input  logic [DW-1:0]     com_wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DW-1:0]     rd_a,
    output logic [DW-1:0]     rd_b,
    output logic [DW-1:0]     com
);

    logic [DW-1:0] samp [NUM_CH];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    samp[g] <= DW'(sample_default(g));
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    samp[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            com <= '0;
        end else if (com_wr_en) begin
            com <= com_wr_data;
        end
    end

    always_comb begin
        rd_a = samp[rd_a_idx];
        rd_b = samp[rd_b_idx];
    end

endmodule

// File: rtl/adc_fe_measure.sv
module adc_fe_measure #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          sgl,
    input  logic          uni,
    input  logic [DW-1:0] sel_val,
    input  logic [DW-1:0] pair_val,
    input  logic [DW-1:0] com_val,
    output logic [DW-1:0] res_hi,
    output logic [DW-1:0] res_lo
);

    localparam int LO_BITS = 2;
    localparam int HI_BITS = DW - LO_BITS;

    logic [DW-1:0] ref_val;
    logic [DW-1:0] diff;
    logic [DW-1:0] coded;

    always_comb begin
        ref_val = sgl ? com_val : pair_val;
        diff    = sel_val - ref_val;
        coded   = diff ^ {~uni, {(DW-1){1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
        end else if (load) begin
            res_hi <= {{LO_BITS{1'b0}}, coded[DW-1:LO_BITS]};
            res_lo <= {coded[LO_BITS-1:0], {HI_BITS{1'b0}}};
        end
    end

endmodule

// File: rtl/adc_fe_seq.sv
module adc_fe_seq
    import adc_fe_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          start,
    input  logic          pwr,
    input  logic [DW-1:0] res_hi,
    input  logic [DW-1:0] res_lo,
    output logic          load_res,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte,
    output logic          irq
);

    seq_state_t    state;
    seq_state_t    state_nxt;
    logic [DW-1:0] reply;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions and reply selection
    always_comb begin
        state_nxt = state;
        reply     = '0;
        load_res  = 1'b0;
        if (rx_valid) begin
            if (start) begin
                if (pwr) begin
                    state_nxt = SQ_HIGH;   // ARM
                    load_res  = 1'b1;
                end else begin
                    state_nxt = SQ_IDLE;   // SLEEP
                end
            end else begin
                unique case (state)
                    SQ_IDLE: state_nxt = SQ_IDLE;            // HOLD
                    SQ_HIGH: begin
                        reply     = res_hi;                  // ADVANCE
                        state_nxt = SQ_LOW;
                    end
                    SQ_LOW: begin
                        reply     = res_lo;                  // ADVANCE
                        state_nxt = SQ_DONE;
                    end
                    SQ_DONE: state_nxt = SQ_DONE;            // HOLD
                endcase
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
            irq      <= 1'b0;
        end else begin
            tx_valid <= rx_valid;
            tx_byte  <= rx_valid ? reply : '0;
            if (rx_valid && start && pwr) begin
                irq <= 1'b1;
            end else if (rx_valid && !start) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_spi_frontend.sv
module adc_spi_frontend
    import adc_fe_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 8,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              irq,
    input  logic              smp_wr_en,
    input  logic [IDX_W-1:0]  smp_wr_idx,
    input  logic [DW-1:0]     smp_wr_data,
    input  logic              com_wr_en,
    input  logic [DW-1:0]     com_wr_data
);

    ctrl_t            ctrl;
    logic [IDX_W-1:0] sel_idx;
    logic [IDX_W-1:0] pair_idx;
    logic [DW-1:0]    sel_val;
    logic [DW-1:0]    pair_val;
    logic [DW-1:0]    com_val;
    logic [DW-1:0]    res_hi;
    logic [DW-1:0]    res_lo;
    logic             load_res;
    logic [DW-1:0]    tx_word;

    always_comb begin
        ctrl = ctrl_t'(rx_byte);
    end

    adc_fe_chan_map #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_map (
        .ctrl     (ctrl),
        .sel_idx  (sel_idx),
        .pair_idx (pair_idx)
    );

    adc_fe_sample_bank #(.NUM_CH(NUM_CH), .DW(DW), .IDX_W(IDX_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (smp_wr_en),
        .wr_idx      (smp_wr_idx),
        .wr_data     (smp_wr_data),
        .com_wr_en   (com_wr_en),
        .com_wr_data (com_wr_data),
        .rd_a_idx    (sel_idx),
        .rd_b_idx    (pair_idx),
        .rd_a        (sel_val),
        .rd_b        (pair_val),
        .com         (com_val)
    );

    adc_fe_measure #(.DW(DW)) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_res),
        .sgl      (ctrl.sgl),
        .uni      (ctrl.uni),
        .sel_val  (sel_val),
        .pair_val (pair_val),
        .com_val  (com_val),
        .res_hi   (res_hi),
        .res_lo   (res_lo)
    );

    adc_fe_seq #(.DW(DW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .start    (ctrl.start),
        .pwr      (ctrl.pwr),
        .res_hi   (res_hi),
        .res_lo   (res_lo),
        .load_res (load_res),
        .tx_valid (tx_valid),
        .tx_byte  (tx_word),
        .irq      (irq)
    );

    always_comb begin
        tx_byte = 8'(tx_word);
    end

endmodule

// File: rtl/adc_fe_checker.sv
module adc_fe_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [7:0]    rx_byte,
    input logic          tx_valid,
    input logic [7:0]    tx_byte,
    input logic          irq,
    input logic [DW-1:0] res_hi,
    input logic [DW-1:0] res_lo
);

    AST_CMD_REPLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_byte[7] |=> tx_byte == 8'h00);                          // R9
    AST_IRQ_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_byte[7] && rx_byte[1] |=> irq);                         // R11
    AST_IRQ_OFF_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_byte[7] |=> !irq);                                     // R11
    AST_FILLER_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_byte[7] |=> $stable(res_hi) && $stable(res_lo));       // R1
    AST_TX_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> tx_valid);                                                // R12
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !tx_valid && tx_byte == 8'h00);                          // R12
    AST_REPLY_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_byte[7:6] == 2'b00) || (tx_byte[5:0] == 6'd0));      // R8
    AST_HI_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        res_hi[DW-1:DW-2] == 2'b00);                                           // R8

endmodule

bind adc_spi_frontend adc_fe_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .irq      (irq),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
);

// File: tb/adc_spi_frontend_bench.sv
`timescale 1ns/1ps
module adc_spi_frontend_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       smp_wr_en = 1'b0;
    logic [2:0] smp_wr_idx = 3'd0;
    logic [7:0] smp_wr_data = 8'h00;
    logic       com_wr_en = 1'b0;
    logic [7:0] com_wr_data = 8'h00;
    logic       smp_wr_en4;

    logic       tv8, tv4, irq8, irq4;
    logic [7:0] tx8, tx4;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m8 [8];
    logic [7:0] m4 [8];
    logic [7:0] mcom;

    always #2 clk = ~clk;

    assign smp_wr_en4 = smp_wr_en && (smp_wr_idx < 3'd4);

    adc_spi_frontend #(.NUM_CH(8)) u_adc_spi_frontend (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tv8), .tx_byte(tx8), .irq(irq8),
        .smp_wr_en(smp_wr_en), .smp_wr_idx(smp_wr_idx), .smp_wr_data(smp_wr_data),
        .com_wr_en(com_wr_en), .com_wr_data(com_wr_data)
    );

    adc_spi_frontend #(.NUM_CH(4)) u_adc_spi_frontend4 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tv4), .tx_byte(tx4), .irq(irq4),
        .smp_wr_en(smp_wr_en4), .smp_wr_idx(smp_wr_idx[1:0]), .smp_wr_data(smp_wr_data),
        .com_wr_en(com_wr_en), .com_wr_data(com_wr_data)
    );

    // {command, first reply, second reply} for the 8-input build at reset defaults
    localparam logic [23:0] VEC [7] = '{
        24'h8E_3C_00, 24'h86_1C_00, 24'h9E_34_00, 24'h9A_04_00,
        24'hAA_04_00, 24'hCA_3C_00, 24'hC2_1C_00
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int nch, input logic [7:0] c, input logic [7:0] s [8],
                                          input logic [7:0] cm);
        int idx;
        logic [7:0] m;
        idx = (nch == 8) ? {c[5], c[4], c[6]} : {c[5], c[6]};
        m = c[2] ? (s[idx] - cm) : (s[idx] - s[idx ^ 1]);
        if (!c[3]) m[7] = ~m[7];
        return {2'b00, m[7:2], m[1:0], 6'd0};
    endfunction

    task automatic models_default();
        for (int i = 0; i < 8; i++) begin
            m8[i] = 8'(240 - 16 * i);
            m4[i] = (i < 4) ? 8'(240 - 16 * i) : 8'h00;
        end
        mcom = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        models_default();
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r8, output logic [7:0] r4);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        r8 = tx8;
        r4 = tx4;
        check("R12 tx_valid 8", {7'd0, tv8}, 8'h01);
        check("R12 tx_valid 4", {7'd0, tv4}, 8'h01);
    endtask

    task automatic wr_smp(input int idx, input logic [7:0] v);
        @(negedge clk);
        smp_wr_en   = 1'b1;
        smp_wr_idx  = 3'(idx);
        smp_wr_data = v;
        @(negedge clk);
        smp_wr_en = 1'b0;
        m8[idx] = v;
        if (idx < 4) m4[idx] = v;
    endtask

    task automatic wr_com(input logic [7:0] v);
        @(negedge clk);
        com_wr_en   = 1'b1;
        com_wr_data = v;
        @(negedge clk);
        com_wr_en = 1'b0;
        mcom = v;
    endtask

    // One command plus three fillers, both builds compared with the model
    task automatic run_cmd(input string req, input logic [7:0] c);
        logic [7:0] r8, r4;
        logic [15:0] e8, e4;
        e8 = model(8, c, m8, mcom);
        e4 = model(4, c, m4, mcom);
        xfer(c, r8, r4);
        check({req, " R9 cmd reply"}, r8, 8'h00);
        check({req, " R11 irq"}, {7'd0, irq8}, 8'h01);
        xfer(8'h00, r8, r4);
        check({req, " R8 hi 8"}, r8, e8[15:8]);
        check({req, " R4 hi 4"}, r4, e4[15:8]);
        xfer(8'h00, r8, r4);
        check({req, " R8 lo 8"}, r8, e8[7:0]);
        check({req, " R4 lo 4"}, r4, e4[7:0]);
        xfer(8'h00, r8, r4);
        check({req, " R9 tail"}, r8, 8'h00);
        check({req, " R11 irq off"}, {7'd0, irq8}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] r8, r4;
        models_default();
        do_reset();

        // R10: reset state at the ports
        check("R10 tx after reset", tx8, 8'h00);
        check("R10 irq after reset", {7'd0, irq8}, 8'h00);
        xfer(8'h00, r8, r4);
        check("R10 idle reply", r8, 8'h00);
        check("R10 idle reply 4", r4, 8'h00);

        // Table walk: reset default samples, 8-input build (R10, R3, R6, R7)
        for (int v = 0; v < 7; v++) begin
            xfer(VEC[v][23:16], r8, r4);
            check("R9 table cmd", r8, 8'h00);
            xfer(8'h00, r8, r4);
            check("R10 table hi", r8, VEC[v][15:8]);
            check("R4 table hi 4", r4, model(4, VEC[v][23:16], m4, mcom) >> 8);
            xfer(8'h00, r8, r4);
            check("R8 table lo", r8, VEC[v][7:0]);
            xfer(8'h00, r8, r4);
            check("R9 table tail", r8, 8'h00);
        end

        // R13, R5: new samples with low bits set, and a nonzero reference
        for (int i = 0; i < 8; i++) wr_smp(i, 8'(i * 37 + 5));
        wr_com(8'h13);
        for (int sel = 0; sel < 8; sel++)
            for (int uni = 0; uni < 2; uni++)
                for (int sgl = 0; sgl < 2; sgl++)
                    run_cmd("R3 R5 R6 R7 R13 sweep",
                            8'(8'h82 | (sel << 4) | (uni << 3) | (sgl << 2) | (sel & 1)));

        // R5: reference above the sample wraps modulo 256 (0x05 - 0x13 = 0xF2)
        run_cmd("R5 wrap", 8'h8E);
        xfer(8'h8E, r8, r4);
        xfer(8'h00, r8, r4);
        check("R5 wrap hi", r8, 8'h3C);
        xfer(8'h00, r8, r4);
        check("R5 wrap lo", r8, 8'h80);

        // R2: unpowered command silences replies, irq untouched
        xfer(8'h8E, r8, r4);
        xfer(8'h81, r8, r4);
        check("R2 sleep reply", r8, 8'h00);
        check("R2 irq kept", {7'd0, irq8}, 8'h01);
        xfer(8'h00, r8, r4);
        check("R2 after sleep 1", r8, 8'h00);
        xfer(8'h00, r8, r4);
        check("R2 after sleep 2", r8, 8'h00);
        check("R11 filler clears irq", {7'd0, irq8}, 8'h00);

        // R9: restart in the middle of a reply
        xfer(8'h8E, r8, r4);
        xfer(8'h00, r8, r4);
        check("R9 first hi", r8, 8'h3C);
        xfer(8'h86, r8, r4);
        check("R9 restart reply", r8, 8'h00);
        xfer(8'h00, r8, r4);
        check("R9 restarted hi", r8, 8'h1C);

        // R1: filler with low bits set neither re-arms nor alters the result
        xfer(8'h8E, r8, r4);
        xfer(8'h7F, r8, r4);
        check("R1 filler hi", r8, 8'h3C);
        xfer(8'h7F, r8, r4);
        check("R1 filler lo", r8, 8'h80);
        xfer(8'h7F, r8, r4);
        check("R1 no re-arm", r8, 8'h00);

        // R10: reset mid-sequence restores defaults
        xfer(8'h8E, r8, r4);
        do_reset();
        check("R10 irq cleared", {7'd0, irq8}, 8'h00);
        xfer(8'h00, r8, r4);
        check("R10 sequence cleared", r8, 8'h00);
        run_cmd("R10 defaults back", 8'h8E);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule